// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple single-word host port and one SDR SDRAM device. After reset it runs the power-up sequence: a programmable idle period, a precharge of all banks, two auto-refresh commands and a mode-register load. When that sequence is done it raises its ready signal and serves host requests one at a time.

Each request opens its row, issues one column read or write with auto-precharge, and then waits out the recovery time before the next row can be opened. Reads return one data word on a response strobe. The timing gaps between commands come from parameters, so the same block fits different speed grades and clock rates.

The host address is linear. Bits [7:0] are the column, bits [19:8] are the row and bits [21:20] are the bank. Every memory-side output comes from a register. The data pads are left outside the block, which exposes a data-out bus, an output enable and a data-in bus.

Top module: `sdr_seq`

## Requirements
- R1: While reset is held, `cs_n` is high, `req_ready` is low and `dq_oe` is low. After reset is released, `cke` goes high and stays high. No command (`cs_n` low) appears within the first INIT_WAIT cycles after release.
- R2: The first four commands, in this order, are:
  - PRECHARGE with `a[10]`=1 (all banks);
  - AUTO REFRESH;
  - AUTO REFRESH;
  - LOAD MODE REGISTER with `a` equal to MODE_OP.
  
  `req_ready` stays low until the LOAD MODE REGISTER has been sent.
- R3: Commands are coded on {`ras_n`,`cas_n`,`we_n`] as follows, each sent with `cs_n` low: LOAD MODE 000, AUTO REFRESH 001, PRECHARGE 010, ACTIVE 011, WRITE 100, READ 101. Every other cycle is a deselect, with `cs_n` high and the three lines at 111.
- R4: An ACTIVE command carries the row `req_addr[19:8]` on `a` and the bank `req_addr[21:20]` on `ba`.
- R5: A READ or WRITE command carries the column `req_addr[7:0]` on `a[7:0]`, with `a[10]`=1 (auto-precharge) and all other `a` bits 0. It carries the same bank on `ba` as the preceding ACTIVE.
- R6: The column command follows its ACTIVE after exactly T_RCD cycles.
- R7: In the WRITE cycle:
  - `dq_oe` is high and `dq_out` equals the write data;
  - `dqm` is the bitwise inverse of `req_be`, so bit i masks byte i.
  
  `dq_oe` is high in no other cycle.
- R8: READ is sent with `dqm` = 0. The word present on `dq_in` CAS_LAT cycles after the memory samples the READ is returned on `rsp_rdata`, with `rsp_valid` high for exactly one cycle.
- R9: Once a request is accepted, `req_ready` is low until the access completes. The next ACTIVE comes more than T_WRP cycles after a WRITE, and at least CAS_LAT+T_RP cycles after a READ.
- R10: A request is taken only when `req_valid` and `req_ready` are both high. A request raised during power-up waits, and its ACTIVE appears only after the mode-register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Linear word address (bank, row, column) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for a write |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_rdata | output | 16 | Read data |
| cs_n | output | 1 | Chip select, low on command cycles |
| ras_n | output | 1 | Row strobe command line |
| cas_n | output | 1 | Column strobe command line |
| we_n | output | 1 | Write enable command line |
| ba | output | 2 | Bank address |
| a | output | 12 | Address / op-code bus |
| dqm | output | 2 | Byte mask lines |
| cke | output | 1 | Clock enable |
| dq_out | output | 16 | Data toward the pads |
| dq_oe | output | 1 | Pad output enable |
| dq_in | input | 16 | Data from the pads |

## Verification
The bound checker watches the following properties on every cycle:
- the coupling between chip select and the command code;
- that auto-precharge is set on every column command;
- that the output enable appears only with a WRITE;
- that reads are never masked;
- that the response strobe is a single-cycle pulse;
- that the bus is quiet while the block is ready;
- that CKE stays high.

Other behaviours are visible only in the bench's scenarios, which run against a memory model:
- the power-up ordering and the mode op-code;
- the exact gaps between commands;
- the row, bank and column fields;
- the inverted byte masks and their effect on stored data;
- read data arriving at the right CAS latency;
- a request held through power-up.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    RCW_LMR  = 3'b000,
    RCW_REF  = 3'b001,
    RCW_PRE  = 3'b010,
    RCW_ACT  = 3'b011,
    RCW_WR   = 3'b100,
    RCW_RD   = 3'b101,
    RCW_IDLE = 3'b111
  } rcw_e;

  typedef struct packed {
    logic cs_n;
    rcw_e rcw;
  } cmd_t;

  typedef enum logic [3:0] {
    S_PWR, S_PRE, S_REF1, S_REF2, S_MRS, S_IDLE, S_RCD, S_RDW, S_REC
  } st_e;

  localparam cmd_t CMD_DESEL = '{cs_n: 1'b1, rcw: RCW_IDLE};

  function automatic int dmax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/sdr_addr_map.sv
module sdr_addr_map #(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  localparam int ADDR_W = COL_W + ROW_W + BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  row,
  output logic [BANK_W-1:0] bank
);
  assign col  = addr[COL_W-1:0];
  assign row  = addr[COL_W+ROW_W-1:COL_W];
  assign bank = addr[ADDR_W-1:COL_W+ROW_W];
endmodule

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= W'(RST_VAL);
    else if (load)    cnt <= load_val;
    else if (!zero)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
  import sdr_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_t              nxt_cmd,
  input  logic [BANK_W-1:0] nxt_ba,
  input  logic [ROW_W-1:0]  nxt_a,
  input  logic [BE_W-1:0]   nxt_dqm,
  input  logic [DATA_W-1:0] nxt_dout,
  input  logic              nxt_oe,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a,
  output logic [BE_W-1:0]   dqm,
  output logic              cke,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n   <= 1'b1;
      {ras_n, cas_n, we_n} <= 3'b111;
      ba     <= '0;
      a      <= '0;
      dqm    <= '1;
      cke    <= 1'b0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      cs_n   <= nxt_cmd.cs_n;
      {ras_n, cas_n, we_n} <= nxt_cmd.rcw;
      ba     <= nxt_ba;
      a      <= nxt_a;
      dqm    <= nxt_dqm;
      cke    <= 1'b1;
      dq_out <= nxt_dout;
      dq_oe  <= nxt_oe;
    end
  end
endmodule

// File: rtl/sdr_seq.sv
module sdr_seq
  import sdr_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int ROW_W     = 12,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 16,
  parameter int AP_BIT    = 10,
  parameter int INIT_WAIT = 2000,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 2,
  parameter int CAS_LAT   = 2,
  parameter int T_WRP     = 3,
  parameter logic [ROW_W-1:0] MODE_OP = 12'h020,
  localparam int ADDR_W = COL_W + ROW_W + BANK_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a,
  output logic [BE_W-1:0]   dqm,
  output logic              cke,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int MAXD = dmax(dmax(dmax(INIT_WAIT, T_RFC), dmax(T_RP, T_MRD)),
                             dmax(dmax(T_RCD, CAS_LAT), T_WRP));
  localparam int CNT_W = $clog2(MAXD + 1) + 1;

  st_e               state, nxt_state;
  logic              ld, zero, accept, capture;
  logic [CNT_W-1:0]  ld_val;
  cmd_t              nc;
  logic [BANK_W-1:0] nba;
  logic [ROW_W-1:0]  na;
  logic [BE_W-1:0]   ndqm;
  logic [DATA_W-1:0] ndout;
  logic              noe;

  logic [COL_W-1:0]  m_col;
  logic [ROW_W-1:0]  m_row;
  logic [BANK_W-1:0] m_bank;
  logic [COL_W-1:0]  l_col;
  logic [BANK_W-1:0] l_bank;
  logic              l_we;
  logic [DATA_W-1:0] l_wd;
  logic [BE_W-1:0]   l_be;

  sdr_addr_map #(.COL_W(COL_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_map (
    .addr(req_addr), .col(m_col), .row(m_row), .bank(m_bank)
  );

  sdr_wait_cnt #(.W(CNT_W), .RST_VAL(INIT_WAIT)) u_cnt (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .zero(zero)
  );

  assign req_ready = (state == S_IDLE);

  always_comb begin
    nxt_state = state;
    ld = 1'b0;  ld_val = '0;
    nc = CMD_DESEL;  nba = '0;  na = '0;  ndqm = '0;  ndout = '0;  noe = 1'b0;
    accept = 1'b0;  capture = 1'b0;
    case (state)
      S_PWR: if (zero) begin
        nc = '{cs_n: 1'b0, rcw: RCW_PRE};  na[AP_BIT] = 1'b1;
        nxt_state = S_PRE;  ld = 1'b1;  ld_val = CNT_W'(T_RP - 1);
      end
      S_PRE: if (zero) begin
        nc = '{cs_n: 1'b0, rcw: RCW_REF};
        nxt_state = S_REF1;  ld = 1'b1;  ld_val = CNT_W'(T_RFC - 1);
      end
      S_REF1: if (zero) begin
        nc = '{cs_n: 1'b0, rcw: RCW_REF};
        nxt_state = S_REF2;  ld = 1'b1;  ld_val = CNT_W'(T_RFC - 1);
      end
      S_REF2: if (zero) begin
        nc = '{cs_n: 1'b0, rcw: RCW_LMR};  na = MODE_OP;
        nxt_state = S_MRS;  ld = 1'b1;  ld_val = CNT_W'(T_MRD - 1);
      end
      S_MRS: if (zero) nxt_state = S_IDLE;
      S_IDLE: if (req_valid) begin
        accept = 1'b1;
        nc = '{cs_n: 1'b0, rcw: RCW_ACT};  na = m_row;  nba = m_bank;
        nxt_state = S_RCD;  ld = 1'b1;  ld_val = CNT_W'(T_RCD - 1);
      end
      S_RCD: if (zero) begin
        na = ROW_W'(l_col);  na[AP_BIT] = 1'b1;  nba = l_bank;  ld = 1'b1;
        if (l_we) begin
          nc = '{cs_n: 1'b0, rcw: RCW_WR};
          ndout = l_wd;  noe = 1'b1;  ndqm = ~l_be;
          nxt_state = S_REC;  ld_val = CNT_W'(T_WRP - 1);
        end else begin
          nc = '{cs_n: 1'b0, rcw: RCW_RD};
          nxt_state = S_RDW;  ld_val = CNT_W'(CAS_LAT);
        end
      end
      S_RDW: if (zero) begin
        capture = 1'b1;
        nxt_state = S_REC;  ld = 1'b1;  ld_val = CNT_W'(T_RP - 1);
      end
      S_REC: if (zero) nxt_state = S_IDLE;
      default: nxt_state = S_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PWR;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      l_col <= '0;  l_bank <= '0;  l_we <= 1'b0;  l_wd <= '0;  l_be <= '0;
    end else begin
      state     <= nxt_state;
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
      if (accept) begin
        l_col <= m_col;  l_bank <= m_bank;  l_we <= req_we;
        l_wd  <= req_wdata;  l_be <= req_be;
      end
    end
  end

  sdr_cmd_reg #(.ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .nxt_cmd(nc), .nxt_ba(nba), .nxt_a(na), .nxt_dqm(ndqm),
    .nxt_dout(ndout), .nxt_oe(noe), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a(a), .dqm(dqm), .cke(cke), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/sdr_seq_chk.sv
module sdr_seq_chk #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  parameter int T_RCD  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ROW_W-1:0]  a,
  input logic [DATA_W/8-1:0] dqm,
  input logic              cke,
  input logic              dq_oe
);
  logic [2:0] code;
  assign code = {ras_n, cas_n, we_n};

  // R3: chip select low exactly when a real command code is present
  p_cs_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n == (code == 3'b111));

  // R5: every column command requests auto-precharge
  p_col_ap_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ras_n && !cas_n) |-> a[AP_BIT]);

  // R7: output enable only together with a WRITE
  p_oe_write_r7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!cs_n && code == 3'b100));

  // R7: a WRITE always drives the pads
  p_write_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && code == 3'b100) |-> dq_oe);

  // R8: reads are never masked
  p_rd_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && code == 3'b101) |-> (dqm == '0));

  // R8: response strobe lasts one cycle
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9: bus quiet while ready for a new request
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cs_n);

  // R6: no command right after ACTIVE when the gap is longer than one
  p_act_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (T_RCD > 1 && !cs_n && code == 3'b011) |=> cs_n);

  // R1: clock enable stays high once out of reset
  p_cke_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cke);
endmodule

bind sdr_seq sdr_seq_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .AP_BIT(AP_BIT), .T_RCD(T_RCD)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a(a),
  .dqm(dqm), .cke(cke), .dq_oe(dq_oe)
);

// File: tb/sdr_seq_tb_top.sv
module sdr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_WAIT = 10, T_RP = 2, T_RFC = 4, T_MRD = 2;
  localparam int T_RCD = 3, CAS_LAT = 2, T_WRP = 3;
  localparam logic [11:0] MODE_OP = 12'h021;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, cs_n, ras_n, cas_n, we_n, cke, dq_oe;
  logic [15:0] rsp_rdata, dq_out;
  logic [15:0] dq_in = 16'h0BAD;
  logic [1:0]  ba, dqm;
  logic [11:0] a;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_seq #(.INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
            .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_WRP(T_WRP), .MODE_OP(MODE_OP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a(a), .dqm(dqm), .cke(cke), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  bit [15:0] mem [int];
  int cyc = 0, ncmd = 0, act_cyc = -1000, col_cyc = -1000, rd_cd = 0, rd_idx = 0;
  bit init_done = 0, last_we = 0, drove = 0;
  logic [2:0]  init_code [4];
  logic [11:0] init_a [4];
  logic [11:0] act_row;
  logic [1:0]  act_bank;

  always @(negedge clk) begin
    if (!rst) begin
      logic [2:0] code;
      int idx;
      cyc++;
      if (drove) begin dq_in = 16'h0BAD; drove = 0; end
      if (rd_cd > 0) begin
        rd_cd--;
        if (rd_cd == 0) begin dq_in = mem.exists(rd_idx) ? mem[rd_idx] : 16'h0; drove = 1; end
      end
      code = {ras_n, cas_n, we_n};
      if (!cs_n) begin
        if (ncmd < 4) begin init_code[ncmd] = code; init_a[ncmd] = a; end
        if (ncmd == 0) chk(cyc > INIT_WAIT, "R1 first command after idle wait", cyc, INIT_WAIT + 1);
        ncmd++;
        if (code == 3'b000) begin
          chk(req_ready == 1'b0, "R2 ready low at mode load", req_ready, 0);
          init_done = 1;
        end
        if (code == 3'b011) begin
          chk(init_done, "R10 ACTIVE only after init", init_done, 1);
          chk(a == req_addr[19:8], "R4 row on ACTIVE", a, req_addr[19:8]);
          chk(ba == req_addr[21:20], "R4 bank on ACTIVE", ba, req_addr[21:20]);
          if (last_we) chk(cyc - col_cyc > T_WRP, "R9 write recovery gap", cyc - col_cyc, T_WRP + 1);
          else chk(cyc - col_cyc >= CAS_LAT + T_RP, "R9 read recovery gap", cyc - col_cyc, CAS_LAT + T_RP);
          act_row = a; act_bank = ba; act_cyc = cyc;
        end
        if (code == 3'b100 || code == 3'b101) begin
          chk(cyc - act_cyc == T_RCD, "R6 ACTIVE to column gap", cyc - act_cyc, T_RCD);
          chk(a == (12'h400 | {4'h0, req_addr[7:0]}), "R5 column address with AP",
              a, 12'h400 | {4'h0, req_addr[7:0]});
          chk(ba == act_bank, "R5 bank on column", ba, act_bank);
          idx = int'({act_bank, act_row, a[7:0]});
          col_cyc = cyc;
          last_we = (code == 3'b100);
          if (code == 3'b100) begin
            chk(dqm == ~req_be, "R7 write mask inverse of enables", dqm, ~req_be);
            chk(dq_oe && dq_out == req_wdata, "R7 write data on pads", dq_out, req_wdata);
            if (!mem.exists(idx)) mem[idx] = 16'h0;
            if (!dqm[0]) mem[idx][7:0]  = dq_out[7:0];
            if (!dqm[1]) mem[idx][15:8] = dq_out[15:8];
          end else begin
            chk(dqm == 2'b00, "R8 read mask low", dqm, 0);
            rd_idx = idx; rd_cd = CAS_LAT;
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  typedef struct packed {
    logic        we;
    logic [21:0] addr;
    logic [15:0] wd;
    logic [1:0]  be;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 22'h3ABC5D, 16'hFFFF, 2'b11, 16'h0000},
    '{1'b0, 22'h3ABC5D, 16'h0000, 2'b00, 16'hFFFF},
    '{1'b1, 22'h3ABC5D, 16'h1234, 2'b01, 16'h0000},
    '{1'b0, 22'h3ABC5D, 16'h0000, 2'b00, 16'hFF34},
    '{1'b1, 22'h0001FF, 16'hABCD, 2'b10, 16'h0000},
    '{1'b0, 22'h0001FF, 16'h0000, 2'b00, 16'hAB00},
    '{1'b1, 22'h2FFF00, 16'h5A5A, 2'b00, 16'h0000},
    '{1'b0, 22'h2FFF00, 16'h0000, 2'b00, 16'h0000},
    '{1'b0, 22'h3ABC5D, 16'h0000, 2'b00, 16'hFF34}
  };

  task automatic do_req(input vec_t v, input string tag);
    req_we = v.we; req_addr = v.addr; req_wdata = v.wd; req_be = v.be;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
    if (!v.we) begin
      for (int w = 0; w < 100 && !rsp_valid; w++) @(negedge clk);
      chk(rsp_valid, {"R8 response strobe ", tag}, rsp_valid, 1);
      chk(rsp_rdata == v.exp, {"R8 read data ", tag}, rsp_rdata, v.exp);
      @(negedge clk);
      chk(!rsp_valid, "R8 single-cycle strobe", rsp_valid, 0);
    end
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n high in reset", cs_n, 1);
    chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
    chk(dq_oe == 1'b0, "R1 oe low in reset", dq_oe, 0);
    // R10: request raised during power-up must wait for init
    req_we = VECS[0].we; req_addr = VECS[0].addr; req_wdata = VECS[0].wd; req_be = VECS[0].be;
    req_valid = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(cke == 1'b1, "R1 cke high after reset", cke, 1);
    chk(req_ready == 1'b0, "R10 not ready during power-up", req_ready, 0);
    for (int i = 0; i < 9; i++) do_req(VECS[i], $sformatf("vec%0d", i));
    chk(init_code[0] == 3'b010 && init_a[0][10], "R2 first is precharge-all",
        {init_code[0], init_a[0]}, {3'b010, 12'h400});
    chk(init_code[1] == 3'b001, "R2 second is refresh", init_code[1], 3'b001);
    chk(init_code[2] == 3'b001, "R2 third is refresh", init_code[2], 3'b001);
    chk(init_code[3] == 3'b000 && init_a[3] == MODE_OP, "R2 fourth is mode load",
        {init_code[3], init_a[3]}, {3'b000, MODE_OP});
    chk(cs_n == 1'b1 && {ras_n, cas_n, we_n} == 3'b111, "R3 deselect when idle",
        {cs_n, ras_n, cas_n, we_n}, 4'hF);
    // reset mid-stream returns to reset state
    rst = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0 && cs_n == 1'b1, "R1 reset re-entry", {req_ready, cs_n}, 2'b01);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule